// File: doc/BRIEF.md
# Clock Generator Strap Latch and Stop Control

This block is the power-up and clock-gating controller of a multi-output clock generator. Before the supply is declared good, the frequency-select straps, a mode strap and a 24/48 MHz strap are read from pins that later carry clocks. A single pin serves as a level-sensitive, active-high power-good strobe. When it goes high, the controller freezes the strap values for the rest of the power cycle. From then on the same pin is an asynchronous, active-low power-down request.

The latched mode decides what two shared pins do. In desktop mode they drive an extra CPU clock pair. In mobile mode they become active-low stop inputs for the CPU group and the stoppable PCI group. Each stop input passes through a two-flop synchronizer and a registered enable stage. An enable therefore moves only on a rising edge of the internal reference clock. The three free-running PCI clocks ignore both stops. A power-down request clears every output enable at once. Only a full reset clears the latched straps.

Top module: `clkgen_strap_ctl`

## Requirements
- R1: After reset and before the strobe has been seen high, `straps_valid_o`, `pd_o`, `dbg_pair_en_o`, `shared_pin_oe_o` and every enable bus are 0, and stop-pin activity does not change that.
- R2: The strap values present when the strobe rises appear on `fsel_o`, `mobile_o` and `sel24_o` by the third rising clock edge after the rise, together with `straps_valid_o`=1. Strap changes after capture do not alter them. The free-running enables are all 1 from the fourth edge onward.
- R3: Once captured, the straps are never recaptured: a later strobe low/high cycle, with the strap pins changed in between, leaves `fsel_o`, `mobile_o` and `sel24_o` unchanged until `rst_n` is asserted.
- R4: After capture, a low level on the strobe pin sets `pd_o`=1 and forces every enable output to 0 without waiting for a clock edge. A high level clears `pd_o` and restores the enables.
- R5: A latched mode strap of 0 (desktop) gives `shared_pin_oe_o`=2'b11 and `dbg_pair_en_o`=1. A latched 1 (mobile) gives `shared_pin_oe_o`=2'b00 and `dbg_pair_en_o`=0.
- R6: In desktop mode both stop inputs are ignored and all CPU and PCI enables stay 1.
- R7: In mobile mode a low `pci_halt_n_i` clears all of `pci_en_o`, while `pci_free_en_o` stays all 1.
- R8: In mobile mode a low `cpu_halt_n_i` clears all of `cpu_en_o`, while `pci_free_en_o` stays all 1.
- R9: A stop-pin change becomes visible on the enables at the third rising clock edge after it, and not before.
- R10: `sel24_o` is the latched 24/48 strap: 1 selects 24 MHz, 0 selects 48 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| rst_n | input | 1 | Full reset, active low (new power cycle) |
| pwrgd_pd_i | input | 1 | Power-good strobe before capture, active-low power-down after |
| fsel_strap_i | input | FSEL_W | Frequency-select strap pins |
| mode_strap_i | input | 1 | Mode strap: 0 desktop, 1 mobile |
| sel24_strap_i | input | 1 | 24/48 strap: 1 = 24 MHz, 0 = 48 MHz |
| cpu_halt_n_i | input | 1 | Shared pin, active-low CPU stop in mobile mode |
| pci_halt_n_i | input | 1 | Shared pin, active-low PCI stop in mobile mode |
| fsel_o | output | FSEL_W | Latched frequency select |
| mobile_o | output | 1 | Latched mode |
| sel24_o | output | 1 | Latched 24/48 select |
| straps_valid_o | output | 1 | Straps have been captured |
| cpu_en_o | output | N_CPU | Stoppable CPU pair enables |
| pci_en_o | output | N_PCI | Stoppable PCI clock enables |
| pci_free_en_o | output | N_PCIF | Free-running PCI clock enables |
| dbg_pair_en_o | output | 1 | Enable of the CPU pair on the shared pins |
| shared_pin_oe_o | output | 2 | Output-drive enables of the two shared pins |
| pd_o | output | 1 | Power-down flag |

## Verification
Power-down and a synchronized stop can land in the same cycle. In that case the combinational power-down mask and the registered stop update act on the same enable bits at once. The bench provokes this in mobile mode. It pulls the PCI stop low and then drops the strobe pin in the very cycle whose rising edge writes the stop into the enable register. It then requires every enable to read 0 during power-down. After release, the PCI group must stay off while the CPU and free-running groups come back. This shows that neither path hides the other's result.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  typedef struct packed {
    logic mobile;
    logic sel_24;
  } strap_mode_t;

  // a stop request counts only in mobile mode and only while the pin is low
  function automatic logic halted(input logic mobile, input logic sync_n);
    return mobile & ~sync_n;
  endfunction

  // a gated lane runs once straps are valid and it is not halted
  function automatic logic lane_on(input logic valid, input logic mobile,
                                   input logic sync_n);
    return valid & ~halted(mobile, sync_n);
  endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int W       = 2,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[LAST];
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import clkctl_pkg::*;
#(
  parameter int FSEL_W = 5,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_pin_i,
  input  logic [FSEL_W-1:0] fsel_pin_i,
  input  logic              mode_pin_i,
  input  logic              sel_pin_i,
  output logic [FSEL_W-1:0] fsel_q_o,
  output strap_mode_t       mode_q_o,
  output logic              valid_o
);
  logic pg_sync;
  logic load_en;
  logic capture_ev;

  bit_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_pg_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pg_pin_i),
    .q_o   (pg_sync)
  );

  // named events for the checks
  assign load_en    = ~valid_o & ~pg_sync;
  assign capture_ev = ~valid_o &  pg_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      fsel_q_o <= '0;
      mode_q_o <= '0;
    end else if (capture_ev) begin
      valid_o <= 1'b1;
    end else if (load_en) begin
      fsel_q_o        <= fsel_pin_i;
      mode_q_o.mobile <= mode_pin_i;
      mode_q_o.sel_24 <= sel_pin_i;
    end
  end

  // R3: once valid, it stays valid for the power cycle
  p_valid_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_o) |-> valid_o);

  // R3: latched straps never move after capture
  p_straps_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_o) |-> ($stable(fsel_q_o) && $stable(mode_q_o)));

  // R2: capture only follows a synchronized high strobe
  p_capture_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(pg_sync));
endmodule

// File: rtl/enable_gate.sv
module enable_gate
  import clkctl_pkg::*;
#(
  parameter int N_CPU  = 2,
  parameter int N_PCI  = 7,
  parameter int N_PCIF = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              mobile_i,
  input  logic              cpu_sync_n_i,
  input  logic              pci_sync_n_i,
  input  logic              pd_i,
  output logic [N_CPU-1:0]  cpu_en_o,
  output logic [N_PCI-1:0]  pci_en_o,
  output logic [N_PCIF-1:0] pcif_en_o,
  output logic              dbg_en_o
);
  logic [N_CPU-1:0]  cpu_q;
  logic [N_PCI-1:0]  pci_q;
  logic [N_PCIF-1:0] pcif_q;
  logic              dbg_q;
  logic              cpu_run, pci_run;

  assign cpu_run = lane_on(valid_i, mobile_i, cpu_sync_n_i);
  assign pci_run = lane_on(valid_i, mobile_i, pci_sync_n_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_q  <= '0;
      pci_q  <= '0;
      pcif_q <= '0;
      dbg_q  <= 1'b0;
    end else begin
      cpu_q  <= {N_CPU{cpu_run}};
      pci_q  <= {N_PCI{pci_run}};
      pcif_q <= {N_PCIF{valid_i}};
      dbg_q  <= valid_i & ~mobile_i;
    end
  end

  // power-down masks the registered enables asynchronously
  assign cpu_en_o  = cpu_q  & {N_CPU{~pd_i}};
  assign pci_en_o  = pci_q  & {N_PCI{~pd_i}};
  assign pcif_en_o = pcif_q & {N_PCIF{~pd_i}};
  assign dbg_en_o  = dbg_q  & ~pd_i;

  // R6: desktop mode ignores both stop pins
  p_desktop_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !mobile_i && $past(valid_i)) |-> ((&cpu_q) && (&pci_q)));

  // R7: the free-running group follows only strap validity
  p_free_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_i) |-> (&pcif_q));

  // R8: a synchronized CPU stop clears the CPU group one edge later
  p_cpu_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_i && mobile_i && !cpu_sync_n_i) |-> (cpu_q == '0));

  // R7: a synchronized PCI stop clears the stoppable PCI group one edge later
  p_pci_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_i && mobile_i && !pci_sync_n_i) |-> (pci_q == '0));
endmodule

// File: rtl/clkgen_strap_ctl.sv
module clkgen_strap_ctl
  import clkctl_pkg::*;
#(
  parameter int FSEL_W = 5,
  parameter int N_CPU  = 2,
  parameter int N_PCI  = 7,
  parameter int N_PCIF = 3,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrgd_pd_i,
  input  logic [FSEL_W-1:0] fsel_strap_i,
  input  logic              mode_strap_i,
  input  logic              sel24_strap_i,
  input  logic              cpu_halt_n_i,
  input  logic              pci_halt_n_i,
  output logic [FSEL_W-1:0] fsel_o,
  output logic              mobile_o,
  output logic              sel24_o,
  output logic              straps_valid_o,
  output logic [N_CPU-1:0]  cpu_en_o,
  output logic [N_PCI-1:0]  pci_en_o,
  output logic [N_PCIF-1:0] pci_free_en_o,
  output logic              dbg_pair_en_o,
  output logic [1:0]        shared_pin_oe_o,
  output logic              pd_o
);
  localparam int N_STOP = 2;

  strap_mode_t       mode_q;
  logic              valid;
  logic [N_STOP-1:0] halt_sync_n;

  strap_capture #(.FSEL_W(FSEL_W), .STAGES(STAGES)) u_straps (
    .clk        (clk),
    .rst_n      (rst_n),
    .pg_pin_i   (pwrgd_pd_i),
    .fsel_pin_i (fsel_strap_i),
    .mode_pin_i (mode_strap_i),
    .sel_pin_i  (sel24_strap_i),
    .fsel_q_o   (fsel_o),
    .mode_q_o   (mode_q),
    .valid_o    (valid)
  );

  bit_sync #(.W(N_STOP), .STAGES(STAGES), .RST_VAL(1'b1)) u_halt_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({pci_halt_n_i, cpu_halt_n_i}),
    .q_o   (halt_sync_n)
  );

  // after capture the strobe pin is an asynchronous power-down request
  assign pd_o = valid & ~pwrgd_pd_i;

  enable_gate #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_PCIF(N_PCIF)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_i      (valid),
    .mobile_i     (mode_q.mobile),
    .cpu_sync_n_i (halt_sync_n[0]),
    .pci_sync_n_i (halt_sync_n[1]),
    .pd_i         (pd_o),
    .cpu_en_o     (cpu_en_o),
    .pci_en_o     (pci_en_o),
    .pcif_en_o    (pci_free_en_o),
    .dbg_en_o     (dbg_pair_en_o)
  );

  assign mobile_o        = mode_q.mobile;
  assign sel24_o         = mode_q.sel_24;
  assign straps_valid_o  = valid;
  assign shared_pin_oe_o = {2{valid & ~mode_q.mobile}};

  // R4: power-down leaves no enable active
  p_pd_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pd_o |-> ((cpu_en_o == '0) && (pci_en_o == '0) &&
              (pci_free_en_o == '0) && !dbg_pair_en_o));

  // R5: shared pins never drive in mobile mode
  p_mobile_pins_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode_q.mobile) |-> (shared_pin_oe_o == 2'b00 && !dbg_pair_en_o));

  // R1: nothing is enabled before straps are captured
  p_idle_before_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (!pd_o && (cpu_en_o == '0) && (pci_en_o == '0) &&
                (pci_free_en_o == '0)));
endmodule

// File: tb/test_clkgen_strap_ctl.sv
`timescale 1ns/1ps
module test_clkgen_strap_ctl;
  localparam int FSEL_W = 5;
  localparam int N_CPU  = 2;
  localparam int N_PCI  = 7;
  localparam int N_PCIF = 3;

  logic clk = 1'b0;
  logic rst_n, pg, mode, sel, cpu_n, pci_n;
  logic [FSEL_W-1:0] fsel;
  logic [FSEL_W-1:0] fsel_o;
  logic mobile_o, sel24_o, valid_o, dbg_o, pd_o;
  logic [N_CPU-1:0]  cpu_en;
  logic [N_PCI-1:0]  pci_en;
  logic [N_PCIF-1:0] free_en;
  logic [1:0]        oe;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  clkgen_strap_ctl i_clkgen_strap_ctl (
    .clk(clk), .rst_n(rst_n), .pwrgd_pd_i(pg), .fsel_strap_i(fsel),
    .mode_strap_i(mode), .sel24_strap_i(sel), .cpu_halt_n_i(cpu_n),
    .pci_halt_n_i(pci_n), .fsel_o(fsel_o), .mobile_o(mobile_o),
    .sel24_o(sel24_o), .straps_valid_o(valid_o), .cpu_en_o(cpu_en),
    .pci_en_o(pci_en), .pci_free_en_o(free_en), .dbg_pair_en_o(dbg_o),
    .shared_pin_oe_o(oe), .pd_o(pd_o)
  );

  localparam logic [N_CPU-1:0]  CPU_ALL  = '1;
  localparam logic [N_PCI-1:0]  PCI_ALL  = '1;
  localparam logic [N_PCIF-1:0] FREE_ALL = '1;

  // {cpu_n, pci_n, cpu expected on, pci expected on, free expected on}
  localparam logic [4:0] VEC [0:4] = '{5'b11111, 5'b01011, 5'b10101,
                                       5'b00001, 5'b11111};

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_groups(input string tag, input logic c, input logic p,
                            input logic f);
    chk({tag, " cpu"},  32'(cpu_en),  c ? 32'(CPU_ALL)  : 32'd0);
    chk({tag, " pci"},  32'(pci_en),  p ? 32'(PCI_ALL)  : 32'd0);
    chk({tag, " free"}, 32'(free_en), f ? 32'(FREE_ALL) : 32'd0);
  endtask

  task automatic power_up(input logic [FSEL_W-1:0] fs, input logic md,
                          input logic s24);
    rst_n = 1'b0; pg = 1'b0; fsel = fs; mode = md; sel = s24;
    cpu_n = 1'b1; pci_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    pg = 1'b1;
    repeat (6) @(negedge clk);
    fsel = ~fs; mode = ~md; sel = ~s24;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog all requirements act=hung exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state before the strobe
    rst_n = 1'b0; pg = 1'b0; fsel = 5'h0A; mode = 1'b1; sel = 1'b0;
    cpu_n = 1'b1; pci_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cpu_n = 1'b0; pci_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 valid", 32'(valid_o), 0);
    chk("R1 pd", 32'(pd_o), 0);
    chk("R1 oe", 32'(oe), 0);
    chk("R1 dbg", 32'(dbg_o), 0);
    chk_groups("R1", 1'b0, 1'b0, 1'b0);

    // R2 R5 R10: mobile capture, then vector walk of stop patterns (R7 R8)
    power_up(5'h13, 1'b1, 1'b1);
    chk("R2 valid", 32'(valid_o), 1);
    chk("R2 fsel", 32'(fsel_o), 32'h13);
    chk("R2 mode", 32'(mobile_o), 1);
    chk("R10 sel24", 32'(sel24_o), 1);
    chk("R5 mobile oe", 32'(oe), 0);
    chk("R5 mobile dbg", 32'(dbg_o), 0);
    for (int i = 0; i <= 4; i++) begin
      cpu_n = VEC[i][4]; pci_n = VEC[i][3];
      repeat (4) @(negedge clk);
      chk_groups($sformatf("R7 R8 vec%0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R9: latency of a CPU stop is three rising edges
    cpu_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 early", 32'(cpu_en), 32'(CPU_ALL));
    @(negedge clk);
    chk("R9 on time", 32'(cpu_en), 0);
    cpu_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 early release", 32'(cpu_en), 0);
    @(negedge clk);
    chk("R9 release", 32'(cpu_en), 32'(CPU_ALL));

    // R4 with a PCI stop landing in the same cycle
    pci_n = 1'b0;
    repeat (2) @(negedge clk);
    pg = 1'b0;
    #1;
    chk("R4 pd set", 32'(pd_o), 1);
    chk_groups("R4 pd", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk_groups("R4 pd hold", 1'b0, 1'b0, 1'b0);
    fsel = 5'h1F; mode = 1'b0; sel = 1'b0;
    repeat (4) @(negedge clk);
    pg = 1'b1;
    #1;
    chk("R4 pd clear", 32'(pd_o), 0);
    chk_groups("R4 release", 1'b1, 1'b0, 1'b1);
    repeat (6) @(negedge clk);
    // R3: the strobe cycle above did not recapture
    chk("R3 fsel", 32'(fsel_o), 32'h13);
    chk("R3 mode", 32'(mobile_o), 1);
    chk("R3 sel24", 32'(sel24_o), 1);
    pci_n = 1'b1;

    // R5 R6 R10: desktop capture ignores stop pins
    power_up(5'h04, 1'b0, 1'b0);
    chk("R2 fsel desktop", 32'(fsel_o), 32'h04);
    chk("R10 sel48", 32'(sel24_o), 0);
    chk("R5 desktop oe", 32'(oe), 32'h3);
    chk("R5 desktop dbg", 32'(dbg_o), 1);
    cpu_n = 1'b0; pci_n = 1'b0;
    repeat (5) @(negedge clk);
    chk_groups("R6", 1'b1, 1'b1, 1'b1);
    chk("R6 dbg", 32'(dbg_o), 1);

    // R1: full reset clears the capture
    rst_n = 1'b0;
    #1;
    chk("R1 reset valid", 32'(valid_o), 0);
    chk("R1 reset fsel", 32'(fsel_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule